// File: doc/BRIEF.md
# DMA and Cache Request Packet Segmenter

This block turns transfer commands into network packets. A command names a primitive kind (Write or Read), a source word address, a destination word address and a length in words. Commands arrive on two ports: a descriptor port fed by user-level DMA, and a dedicated command port used by the cache controller for write-backs on replacement and fills on miss. Both ports produce the same packet format.

Each packet starts with one header beat carrying the kind, source, destination and segment length. A Write packet then carries one payload beat per word, read from a local word memory. A Read packet is the header alone. A transfer longer than `MAXW` words becomes a series of packets. Each packet after the first starts `MAXW` words further on, and the last packet carries what remains. Between packets the engine picks the next source, and the cache port always wins that choice.

Top module: `pkt_segmenter`

## Requirements
- R1: After reset, `out_valid` is 0 and both `dma_ready` and `cc_ready` are 1.
- R2: The header beat has `out_head`=1. It carries `out_write` (1 = Write, 0 = Read), the segment's `out_src` and `out_dst`, and `out_len` = words in this segment. `out_data` is 0 on a header beat.
- R3: A command of length L is split into ceil(L/`MAXW`) packets. Every packet except the last is `MAXW` words long, and the last carries the remainder.
- R4: Each packet after the first has source and destination addresses larger by the sum of the lengths of the packets before it from that command.
- R5: A Read packet is the header beat only, and that beat has `out_last`=1.
- R6: A Write packet has exactly `out_len` payload beats after its header, with `out_head`=0. Beat i carries `mem_rdata` for `mem_addr` = segment source + i, and `out_last` is 1 on the final beat only.
- R7: Commands on the cache port produce the same Write and Read packets, by the same rules, as the DMA port.
- R8: Source selection happens only between packets. When a cache command is pending at a packet boundary, it is served before any further DMA packet, and a packet once started is never interrupted.
- R9: A command of length 0 is accepted and produces no packet.
- R10: While `out_valid` is 1 and `out_ready` is 0, every output beat field holds its value into the next cycle.
- R11: A port's ready is 0 from the cycle after one of its non-empty commands is accepted until that command's last packet completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_valid | input | 1 | DMA descriptor present |
| dma_ready | output | 1 | DMA descriptor accepted this cycle if valid |
| dma_write | input | 1 | 1 = Write transfer, 0 = Read transfer |
| dma_src | input | AW | Source word address |
| dma_dst | input | AW | Destination word address |
| dma_len | input | LW | Length in words |
| cc_valid | input | 1 | Cache command present |
| cc_ready | output | 1 | Cache command accepted this cycle if valid |
| cc_write | input | 1 | 1 = write-back, 0 = fill |
| cc_src | input | AW | Source word address |
| cc_dst | input | AW | Destination word address |
| cc_len | input | LW | Length in words |
| mem_addr | output | AW | Local memory word address for the payload |
| mem_rdata | input | DW | Word at `mem_addr`, same cycle |
| out_valid | output | 1 | Beat present |
| out_ready | input | 1 | Beat taken |
| out_head | output | 1 | Beat is a header |
| out_last | output | 1 | Final beat of the packet |
| out_write | output | 1 | Packet kind, 1 = Write |
| out_src | output | AW | Segment source address |
| out_dst | output | AW | Segment destination address |
| out_len | output | LW | Segment length in words |
| out_data | output | DW | Payload word |

## Verification
The bench builds the block with `MAXW`=4, `AW`=16, `LW`=8 and `DW`=32. The small packet limit means lengths 3, 4, 9, 10 and 12 cover a short single packet, an exact fit, and splits that end in remainders of 1, 2 and a full segment. A 12-word DMA command with a cache command posted during its first packet shows the cache packet placed between DMA segments. Random back-pressure on `out_ready` exercises beat holding throughout.

// File: rtl/pkt_segmenter.sv
module pkt_segmenter #(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int LW   = 8,
  parameter int MAXW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_valid,
  output logic          dma_ready,
  input  logic          dma_write,
  input  logic [AW-1:0] dma_src,
  input  logic [AW-1:0] dma_dst,
  input  logic [LW-1:0] dma_len,
  input  logic          cc_valid,
  output logic          cc_ready,
  input  logic          cc_write,
  input  logic [AW-1:0] cc_src,
  input  logic [AW-1:0] cc_dst,
  input  logic [LW-1:0] cc_len,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_head,
  output logic          out_last,
  output logic          out_write,
  output logic [AW-1:0] out_src,
  output logic [AW-1:0] out_dst,
  output logic [LW-1:0] out_len,
  output logic [DW-1:0] out_data
);
  localparam logic [LW-1:0] SEGMAX = LW'(MAXW);

  // context 0 = DMA, context 1 = cache
  logic [1:0]    busy, wr, ld, in_wr;
  logic [AW-1:0] src [2];
  logic [AW-1:0] dst [2];
  logic [LW-1:0] rem [2];
  logic [AW-1:0] in_src [2];
  logic [AW-1:0] in_dst [2];
  logic [LW-1:0] in_len [2];

  logic          act, sel, body;
  logic [LW-1:0] cnt, seg;
  logic          fire, pkt_end;

  assign in_wr     = {cc_write, dma_write};
  assign in_src[0] = dma_src;
  assign in_src[1] = cc_src;
  assign in_dst[0] = dma_dst;
  assign in_dst[1] = cc_dst;
  assign in_len[0] = dma_len;
  assign in_len[1] = cc_len;

  assign dma_ready = !busy[0];
  assign cc_ready  = !busy[1];
  assign ld[0] = dma_valid && dma_ready && dma_len != '0;
  assign ld[1] = cc_valid && cc_ready && cc_len != '0;

  assign seg       = (rem[sel] > SEGMAX) ? SEGMAX : rem[sel];
  assign out_valid = act;
  assign out_head  = !body;
  assign out_last  = body ? (cnt == seg - 1'b1) : !wr[sel];
  assign out_write = wr[sel];
  assign out_src   = src[sel];
  assign out_dst   = dst[sel];
  assign out_len   = seg;
  assign mem_addr  = src[sel] + AW'(cnt);
  assign out_data  = body ? mem_rdata : '0;
  assign fire      = out_valid && out_ready;
  assign pkt_end   = fire && out_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
      wr   <= '0;
      for (int i = 0; i < 2; i++) begin
        src[i] <= '0;
        dst[i] <= '0;
        rem[i] <= '0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (ld[i]) begin
          busy[i] <= 1'b1;
          wr[i]   <= in_wr[i];
          src[i]  <= in_src[i];
          dst[i]  <= in_dst[i];
          rem[i]  <= in_len[i];
        end else if (pkt_end && sel == 1'(i)) begin
          src[i]  <= src[i] + AW'(seg);
          dst[i]  <= dst[i] + AW'(seg);
          rem[i]  <= rem[i] - seg;
          busy[i] <= rem[i] != seg;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act  <= 1'b0;
      sel  <= 1'b0;
      body <= 1'b0;
      cnt  <= '0;
    end else if (!act) begin
      body <= 1'b0;
      cnt  <= '0;
      if (busy[1]) begin
        act <= 1'b1;
        sel <= 1'b1;
      end else if (busy[0]) begin
        act <= 1'b1;
        sel <= 1'b0;
      end
    end else if (fire) begin
      if (pkt_end) begin
        act  <= 1'b0;
        body <= 1'b0;
        cnt  <= '0;
      end else if (!body) begin
        body <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R10
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable({out_head, out_last, out_write,
                                               out_src, out_dst, out_len, out_data}));
  // R5
  read_hdr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_head && !out_write |-> out_last);
  // R3
  seg_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_len != '0 && out_len <= SEGMAX);
  // R8
  cache_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act && busy[1] |=> act && sel);
  // R8
  no_switch_mid_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act && !pkt_end |=> act && $stable(sel));
  // R6
  payload_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_head |-> out_write && cnt < out_len);
endmodule

// File: tb/test_pkt_segmenter.sv
module test_pkt_segmenter;
  localparam int CLK = 10;
  localparam int AW = 16, DW = 32, LW = 8, MAXW = 4;
  localparam int BW = 3 + AW + AW + LW + DW;

  logic clk = 0, rst_n = 0;
  logic dma_valid = 0, dma_write = 0, cc_valid = 0, cc_write = 0;
  logic [AW-1:0] dma_src = 0, dma_dst = 0, cc_src = 0, cc_dst = 0;
  logic [LW-1:0] dma_len = 0, cc_len = 0;
  logic dma_ready, cc_ready;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic out_valid, out_ready, out_head, out_last, out_write;
  logic [AW-1:0] out_src, out_dst;
  logic [LW-1:0] out_len;
  logic [DW-1:0] out_data;

  int checks = 0, fails = 0;
  logic [BW-1:0] got [256];
  logic [BW-1:0] exp_q [256];
  int ng = 0, ne = 0;
  logic bp_en = 0;
  logic [7:0] lfsr = 8'h5a;

  always #(CLK/2) clk = ~clk;

  assign mem_rdata = {~mem_addr, mem_addr ^ 16'h3c5a};

  pkt_segmenter #(.AW(AW), .DW(DW), .LW(LW), .MAXW(MAXW)) i_pkt_segmenter (
    .clk, .rst_n, .dma_valid, .dma_ready, .dma_write, .dma_src, .dma_dst, .dma_len,
    .cc_valid, .cc_ready, .cc_write, .cc_src, .cc_dst, .cc_len,
    .mem_addr, .mem_rdata, .out_valid, .out_ready, .out_head, .out_last,
    .out_write, .out_src, .out_dst, .out_len, .out_data);

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= bp_en ? lfsr[0] : 1'b1;
  end

  always @(negedge clk)
    if (out_valid && out_ready && ng < 256) begin
      got[ng] = {out_head, out_last, out_write, out_src, out_dst, out_len, out_data};
      ng++;
    end

  task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic exp_pkt(input logic w, input logic [AW-1:0] s, input logic [AW-1:0] d,
                         input int n);
    exp_q[ne++] = {1'b1, !w, w, s, d, LW'(n), DW'(0)};
    if (w)
      for (int i = 0; i < n; i++) begin
        logic [AW-1:0] a = s + AW'(i);
        exp_q[ne++] = {1'b0, i == n - 1, 1'b1, s, d, LW'(n), ~a, a ^ 16'h3c5a};
      end
  endtask

  task automatic exp_cmd(input logic w, input logic [AW-1:0] s, input logic [AW-1:0] d,
                         input int len);
    int off = 0;
    while (off < len) begin
      int n = (len - off > MAXW) ? MAXW : len - off;
      exp_pkt(w, s + AW'(off), d + AW'(off), n);
      off += n;
    end
  endtask

  task automatic post_dma(input logic w, input logic [AW-1:0] s, input logic [AW-1:0] d,
                          input logic [LW-1:0] n);
    @(negedge clk);
    dma_valid = 1; dma_write = w; dma_src = s; dma_dst = d; dma_len = n;
    forever begin
      if (dma_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    dma_valid = 0;
  endtask

  task automatic post_cc(input logic w, input logic [AW-1:0] s, input logic [AW-1:0] d,
                         input logic [LW-1:0] n);
    if (!clk) @(posedge clk);
    @(negedge clk);
    cc_valid = 1; cc_write = w; cc_src = s; cc_dst = d; cc_len = n;
    forever begin
      if (cc_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    cc_valid = 0;
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 4) begin
      @(negedge clk);
      q = (!out_valid && dma_ready && cc_ready) ? q + 1 : 0;
    end
  endtask

  task automatic compare(input string req);
    check({req, " beat count"}, BW'(ng), BW'(ne));
    for (int i = 0; i < ne && i < ng; i++) check(req, got[i], exp_q[i]);
  endtask

  task automatic start();
    wait_idle();
    ng = 0; ne = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 out_valid", BW'(out_valid), BW'(0));
    check("R1 readies", BW'({dma_ready, cc_ready}), BW'(2'b11));
  endtask

  task automatic t_dma_write_split();
    start(); bp_en = 1;
    exp_cmd(1, 16'h0100, 16'h0800, 10);
    post_dma(1, 16'h0100, 16'h0800, 10);
    check("R11 dma_ready busy", BW'(dma_ready), BW'(0));
    wait_idle();
    compare("R2 R3 R4 R6 dma write 10");
    bp_en = 0;
  endtask

  task automatic t_dma_read_split();
    start();
    exp_cmd(0, 16'h0200, 16'h1000, 9);
    post_dma(0, 16'h0200, 16'h1000, 9);
    wait_idle();
    compare("R3 R4 R5 dma read 9");
  endtask

  task automatic t_cache_ops();
    start(); bp_en = 1;
    exp_cmd(1, 16'h0030, 16'h4000, 3);
    post_cc(1, 16'h0030, 16'h4000, 3);
    check("R11 cc_ready busy", BW'(cc_ready), BW'(0));
    wait_idle();
    exp_cmd(0, 16'h0050, 16'h5000, 4);
    post_cc(0, 16'h0050, 16'h5000, 4);
    wait_idle();
    compare("R7 cache write-back and fill");
    bp_en = 0;
  endtask

  task automatic t_exact_fit();
    start();
    exp_cmd(1, 16'hfffe, 16'h0010, 4);
    post_dma(1, 16'hfffe, 16'h0010, 4);
    wait_idle();
    compare("R3 R6 exact max length");
  endtask

  task automatic t_zero_len();
    start();
    post_dma(1, 16'h0300, 16'h0400, 0);
    check("R9 dma_ready after zero", BW'(dma_ready), BW'(1));
    post_cc(0, 16'h0300, 16'h0400, 0);
    wait_idle();
    compare("R9 zero length");
  endtask

  task automatic t_priority();
    start(); bp_en = 1;
    exp_pkt(1, 16'h0100, 16'h0800, 4);
    exp_cmd(0, 16'h0040, 16'h2000, 2);
    exp_pkt(1, 16'h0104, 16'h0804, 4);
    exp_pkt(1, 16'h0108, 16'h0808, 4);
    post_dma(1, 16'h0100, 16'h0800, 12);
    post_cc(0, 16'h0040, 16'h2000, 2);
    wait_idle();
    compare("R8 cache between dma segments");
    bp_en = 0;
  endtask

  initial begin
    #(CLK * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    out_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_dma_write_split();
    t_dma_read_split();
    t_cache_ops();
    t_exact_fit();
    t_zero_len();
    t_priority();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule